// File: doc/BRIEF.md
# Count/Compare Timer with Interrupt

This block keeps a free-running cycle counter beside a compare register and raises a timer interrupt when the counter steps onto the compare value. Software-style write strobes load either register. A hold input (the disable-count bit of the processor's cause register) freezes the counter. The counter advances once per clock, standing in for the nominal 100 MHz count rate.

The interrupt appears on one line of a small interrupt vector. It stays up until software writes the compare register, which is the acknowledge. A status flag mirrors the interrupt, but it is only maintained when a 3-bit revision selector equals 1. For any other selector value the flag keeps its last value. A count write that lands exactly on the compare value does not fire at that instant. The first interrupt after such a write comes one full counter wrap later.

Top module: `cc_timer`

## Requirements
- R1: After reset, the count is 1, the compare register is 0, every interrupt line is low, and the status flag is 0.
- R2: While the hold input is low and no count write is made, the count rises by one on every clock and wraps from all-ones to 0.
- R3: A count write with hold low loads the written value on the next clock, taking priority over the increment.
- R4: A compare write loads the written value on the next clock, whether or not the hold input is set.
- R5: When an increment makes the count equal the compare value, the interrupt line (bit IRQ_LINE, default 7) is high from the same cycle in which the count shows that value. The compare value used is the one being written, if a compare write occurs in that cycle.
- R6: A compare write drops the interrupt on the next clock, unless the same clock's increment matches the new compare value, in which case the interrupt stays high.
- R7: While the hold input is high, the count does not change: both the increment and count writes are ignored, and no match can occur.
- R8: A count write whose value equals the compare value raises no interrupt. The next interrupt comes when the increments bring the count back to that value, 2^CNT_W clocks later.
- R9: With the revision selector equal to 1, the status flag is set on a match and cleared on a compare write, with the same priority as the interrupt. With any other selector value, the flag holds its value.
- R10: Every interrupt vector bit other than IRQ_LINE is always 0.
- R11: Once high, the interrupt stays high until a compare write is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | CNT_W | Count write value |
| cmp_we | input | 1 | Compare write strobe; also acknowledges the interrupt |
| cmp_wdata | input | CNT_W | Compare write value |
| cnt_hold | input | 1 | Disable-count: freezes the counter and blocks count writes |
| rev_sel | input | 3 | Revision selector; value 1 enables status-flag upkeep |
| count_o | output | CNT_W | Current count |
| compare_o | output | CNT_W | Current compare value |
| irq_o | output | IRQ_W | Interrupt vector; only bit IRQ_LINE is ever driven high |
| ti_flag_o | output | 1 | Timer-interrupt status flag |

## Verification
The hardest case to reach from the ports is R8. The count must be written exactly onto the compare value, and then the bench must show both that no interrupt appears and that the match fires a full wrap later. With the default width, a full wrap is too long to simulate. The bench therefore builds the block with an 8-bit counter. It first clears the pending interrupt with a compare write, then writes the count equal to compare. It then watches all 255 following cycles stay quiet before the 256th cycle fires. A second hard case is a compare write that targets the very value the same clock's increment reaches (R5, R6). The vector table reaches it by writing compare to one past the current count while the interrupt is already high.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

  localparam int REV_W      = 3;
  localparam int REV_UPKEEP = 1;

  // Sticky bit update: a set outranks a clear
  function automatic logic sticky_next(input logic cur, input logic set_i, input logic clr_i);
    if (set_i)      return 1'b1;
    else if (clr_i) return 1'b0;
    else            return cur;
  endfunction

endpackage

// File: rtl/cc_count_reg.sv
module cc_count_reg #(
  parameter int CNT_W     = 32,
  parameter int RST_COUNT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_inc,
  output logic             stepping
);

  localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RST_COUNT);

  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign stepping = !hold && !we;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= RST_VAL;
    else if (hold)  cnt_q <= cnt_q;
    else if (we)    cnt_q <= wdata;
    else            cnt_q <= cnt_inc;
  end

endmodule

// File: rtl/cc_match_unit.sv
module cc_match_unit #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             stepping,
  input  logic [CNT_W-1:0] cnt_inc,
  output logic [CNT_W-1:0] cmp_q,
  output logic             hit
);

  logic [CNT_W-1:0] cmp_eff;

  assign cmp_eff = we ? wdata : cmp_q;
  // Only an increment can reach equality; loads never count as a match
  assign hit     = stepping && (cnt_inc == cmp_eff);

  always_ff @(posedge clk) begin
    if (rst)     cmp_q <= '0;
    else if (we) cmp_q <= wdata;
  end

endmodule

// File: rtl/cc_irq_state.sv
module cc_irq_state
  import cc_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             ack,
  input  logic [REV_W-1:0] rev_sel,
  output logic             irq_q,
  output logic             flag_q
);

  logic upkeep;
  assign upkeep = (rev_sel == REV_W'(REV_UPKEEP));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      irq_q <= sticky_next(irq_q, hit, ack);
      if (upkeep) flag_q <= sticky_next(flag_q, hit, ack);
    end
  end

endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int IRQ_W     = 8,
  parameter int IRQ_LINE  = 7,
  parameter int RST_COUNT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             cnt_hold,
  input  logic [REV_W-1:0] rev_sel,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] compare_o,
  output logic [IRQ_W-1:0] irq_o,
  output logic             ti_flag_o
);

  logic [CNT_W-1:0] cnt_inc;
  logic             stepping;
  logic             hit;
  logic             irq_q;

  cc_count_reg #(.CNT_W(CNT_W), .RST_COUNT(RST_COUNT)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .hold     (cnt_hold),
    .we       (cnt_we),
    .wdata    (cnt_wdata),
    .cnt_q    (count_o),
    .cnt_inc  (cnt_inc),
    .stepping (stepping)
  );

  cc_match_unit #(.CNT_W(CNT_W)) u_match (
    .clk      (clk),
    .rst      (rst),
    .we       (cmp_we),
    .wdata    (cmp_wdata),
    .stepping (stepping),
    .cnt_inc  (cnt_inc),
    .cmp_q    (compare_o),
    .hit      (hit)
  );

  cc_irq_state u_irq (
    .clk     (clk),
    .rst     (rst),
    .hit     (hit),
    .ack     (cmp_we),
    .rev_sel (rev_sel),
    .irq_q   (irq_q),
    .flag_q  (ti_flag_o)
  );

  for (genvar g = 0; g < IRQ_W; g++) begin : g_irq
    if (g == IRQ_LINE) begin : g_live
      assign irq_o[g] = irq_q;
    end else begin : g_tied
      assign irq_o[g] = 1'b0;
    end
  end

endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk
  import cc_timer_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int IRQ_W    = 8,
  parameter int IRQ_LINE = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic             cmp_we,
  input logic [CNT_W-1:0] cmp_wdata,
  input logic             cnt_hold,
  input logic [REV_W-1:0] rev_sel,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] compare_o,
  input logic [IRQ_W-1:0] irq_o,
  input logic             ti_flag_o
);

  logic irq_line;
  assign irq_line = irq_o[IRQ_LINE];

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!cnt_hold && !cnt_we) |=> count_o == $past(count_o) + CNT_W'(1));

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!cnt_hold && cnt_we) |=> count_o == $past(cnt_wdata));

  p_cmp_load_r4: assert property (@(posedge clk) disable iff (rst)
    cmp_we |=> compare_o == $past(cmp_wdata));

  p_match_r5: assert property (@(posedge clk) disable iff (rst)
    (!cnt_hold && !cnt_we && !cmp_we && (count_o + CNT_W'(1) == compare_o)) |=> irq_line);

  p_rise_eq_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_line) |-> count_o == compare_o);

  p_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (cmp_we && (cnt_hold || cnt_we)) |=> !irq_line);

  p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_hold |=> $stable(count_o));

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (rev_sel != REV_W'(REV_UPKEEP)) |=> $stable(ti_flag_o));

  p_quiet_lines_r10: assert property (@(posedge clk) disable iff (rst)
    $countones(irq_o) == (irq_line ? 1 : 0));

  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (irq_line && !cmp_we) |=> irq_line);

endmodule

bind cc_timer cc_timer_chk #(.CNT_W(CNT_W), .IRQ_W(IRQ_W), .IRQ_LINE(IRQ_LINE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_we    (cnt_we),
  .cnt_wdata (cnt_wdata),
  .cmp_we    (cmp_we),
  .cmp_wdata (cmp_wdata),
  .cnt_hold  (cnt_hold),
  .rev_sel   (rev_sel),
  .count_o   (count_o),
  .compare_o (compare_o),
  .irq_o     (irq_o),
  .ti_flag_o (ti_flag_o)
);

// File: tb/sim_cc_timer.sv
module sim_cc_timer;

  localparam int W  = 8;
  localparam int IW = 8;
  localparam int NV = 22;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cnt_we = 1'b0;
  logic [W-1:0]  cnt_wdata = '0;
  logic          cmp_we = 1'b0;
  logic [W-1:0]  cmp_wdata = '0;
  logic          cnt_hold = 1'b0;
  logic [2:0]    rev_sel = 3'd1;
  logic [W-1:0]  count_o;
  logic [W-1:0]  compare_o;
  logic [IW-1:0] irq_o;
  logic          ti_flag_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cc_timer #(.CNT_W(W), .IRQ_W(IW), .IRQ_LINE(7), .RST_COUNT(1)) u0 (
    .clk, .rst, .cnt_we, .cnt_wdata, .cmp_we, .cmp_wdata, .cnt_hold, .rev_sel,
    .count_o, .compare_o, .irq_o, .ti_flag_o
  );

  // {cnt_we, cnt_wdata, cmp_we, cmp_wdata, hold, rev, exp_count, exp_irq, exp_flag}
  localparam logic [31:0] VEC [0:NV-1] = '{
    {1'b0, 8'd0,   1'b1, 8'd5,   1'b0, 3'd1, 8'd2,   1'b0, 1'b0}, // R4 compare load
    {1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 3'd1, 8'd3,   1'b0, 1'b0}, // R2
    {1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 3'd1, 8'd4,   1'b0, 1'b0}, // R2
    {1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 3'd1, 8'd5,   1'b1, 1'b1}, // R5 R9 match
    {1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 3'd1, 8'd6,   1'b1, 1'b1}, // R11 held
    {1'b0, 8'd0,   1'b1, 8'd20,  1'b0, 3'd1, 8'd7,   1'b0, 1'b0}, // R6 R9 ack
    {1'b1, 8'd19,  1'b0, 8'd0,   1'b0, 3'd0, 8'd19,  1'b0, 1'b0}, // R3 load
    {1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 3'd0, 8'd20,  1'b1, 1'b0}, // R5, R9 flag kept
    {1'b0, 8'd0,   1'b1, 8'd30,  1'b0, 3'd0, 8'd21,  1'b0, 1'b0}, // R6
    {1'b1, 8'd29,  1'b0, 8'd0,   1'b0, 3'd1, 8'd29,  1'b0, 1'b0}, // R3
    {1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 3'd1, 8'd30,  1'b1, 1'b1}, // R5 R9
    {1'b0, 8'd0,   1'b1, 8'd40,  1'b0, 3'd0, 8'd31,  1'b0, 1'b1}, // R9 clear ignored
    {1'b1, 8'd50,  1'b0, 8'd0,   1'b1, 3'd0, 8'd31,  1'b0, 1'b1}, // R7 write ignored
    {1'b0, 8'd0,   1'b0, 8'd0,   1'b1, 3'd0, 8'd31,  1'b0, 1'b1}, // R7 hold
    {1'b0, 8'd0,   1'b1, 8'd33,  1'b0, 3'd1, 8'd32,  1'b0, 1'b0}, // R9 clear
    {1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 3'd1, 8'd33,  1'b1, 1'b1}, // R5
    {1'b1, 8'd100, 1'b0, 8'd0,   1'b0, 3'd1, 8'd100, 1'b1, 1'b1}, // R11 survives load
    {1'b0, 8'd0,   1'b1, 8'd101, 1'b0, 3'd1, 8'd101, 1'b1, 1'b1}, // R5 R6 set beats ack
    {1'b1, 8'd255, 1'b0, 8'd0,   1'b0, 3'd1, 8'd255, 1'b1, 1'b1}, // R3
    {1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 3'd1, 8'd0,   1'b1, 1'b1}, // R2 wrap
    {1'b0, 8'd0,   1'b1, 8'd2,   1'b0, 3'd1, 8'd1,   1'b0, 1'b0}, // R6
    {1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 3'd1, 8'd2,   1'b1, 1'b1}  // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cnt_we = 1'b0; cmp_we = 1'b0; cnt_hold = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int quiet_bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state (no edge since release yet)
    chk("R1 count", 32'(count_o), 32'd1);
    chk("R1 compare", 32'(compare_o), 32'd0);
    chk("R1 irq", 32'(irq_o), 32'd0);
    chk("R1 flag", 32'(ti_flag_o), 32'd0);

    for (int i = 0; i < NV; i++) begin
      cnt_we    = VEC[i][31];
      cnt_wdata = VEC[i][30:23];
      cmp_we    = VEC[i][22];
      cmp_wdata = VEC[i][21:14];
      cnt_hold  = VEC[i][13];
      rev_sel   = VEC[i][12:10];
      @(negedge clk);
      chk($sformatf("R2/R3/R7 count v%0d", i), 32'(count_o), 32'(VEC[i][9:2]));
      chk($sformatf("R5/R6/R11 irq line v%0d", i), 32'(irq_o[7]), 32'(VEC[i][1]));
      chk($sformatf("R9 flag v%0d", i), 32'(ti_flag_o), 32'(VEC[i][0]));
      chk($sformatf("R10 other lines v%0d", i), 32'(irq_o[6:0]), 32'd0);
      if (VEC[i][22]) chk($sformatf("R4 compare v%0d", i), 32'(compare_o), 32'(VEC[i][21:14]));
    end

    // R8: count written onto compare fires only after a full wrap
    idle_inputs();
    rev_sel = 3'd1;
    cmp_we = 1'b1; cmp_wdata = 8'd200;
    @(negedge clk);
    chk("R6 ack before R8", 32'(irq_o[7]), 32'd0);
    cmp_we = 1'b0;
    cnt_we = 1'b1; cnt_wdata = 8'd200;
    @(negedge clk);
    cnt_we = 1'b0;
    chk("R8 load equal count", 32'(count_o), 32'd200);
    chk("R8 no irq at load", 32'(irq_o[7]), 32'd0);
    quiet_bad = 0;
    for (int k = 0; k < 255; k++) begin
      @(negedge clk);
      if (irq_o[7] !== 1'b0) quiet_bad++;
    end
    chk("R8 quiet for a wrap", 32'(quiet_bad), 32'd0);
    @(negedge clk);
    chk("R8 fires after wrap", 32'(irq_o[7]), 32'd1);
    chk("R8 count at fire", 32'(count_o), 32'd200);

    // R6/R4: compare write acknowledges even while frozen
    cnt_hold = 1'b1; cmp_we = 1'b1; cmp_wdata = 8'd7;
    @(negedge clk);
    idle_inputs();
    chk("R6 ack under hold", 32'(irq_o[7]), 32'd0);
    chk("R4 compare under hold", 32'(compare_o), 32'd7);
    chk("R7 count frozen", 32'(count_o), 32'd200);

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 count after rerun reset", 32'(count_o), 32'd1);
    chk("R1 compare after rerun reset", 32'(compare_o), 32'd0);
    chk("R1 flag after rerun reset", 32'(ti_flag_o), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule